// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block watches over a processor by counting cycles of its own free-running watchdog clock. That clock does not depend on the processor's system clock. Software proves it is still alive by raising a feed request in the system-clock domain. The request travels across to the watchdog domain and clears the counter. If the counter reaches its limit before a feed arrives, the block acts. What it does depends on whether the processor is awake or asleep.

When the processor is running, an overflow holds a system reset request for a fixed number of watchdog cycles. When the processor is asleep, with its clock possibly stopped, the same overflow instead produces a single-cycle wake request, so execution continues where it stopped. Every overflow drives an active-low timeout flag to 0. Software can read the flag later and can set it back to 1 with a clear request. A strap input that is held constant enables the block or keeps it inert for the whole life of the part.

Top module: `wdt_sleep_aware`

## Requirements
- R1: With the block enabled and no feeds, an overflow happens on the TIMEOUT-th watchdog-clock edge after counting starts. Counting starts at power-on reset release, after the end of a reset hold, or after a previous overflow.
- R2: A feed request is captured on one system-clock edge and clears the counter on the third watchdog-clock edge after that capture. The counter then counts up from 0. Feeds spaced well inside the timeout prevent any overflow.
- R3: An overflow while awake raises `sys_reset_req` on the overflow edge and holds it for exactly RST_CYCLES watchdog cycles. During the hold the counter stays at 0 and feeds are ignored. Counting restarts from 0 on the edge after the release.
- R4: An overflow while asleep raises `wake_req` for exactly one watchdog cycle, with no reset request, and the counter restarts from 0.
- R5: The `cpu_sleep` level passes through a two-stage synchronizer. A change made before watchdog edge E1 decides the action of overflows from edge E3 onward.
- R6: Counting, overflow and wake generation continue while `sys_clk` is stopped.
- R7: Every overflow drives the watchdog-domain timeout flag to 0. `timeout_n` shows the flag after two `sys_clk` edges. A watchdog-caused reset hold does not set it back to 1.
- R8: A `status_clr` request sets the flag to 1 on the third watchdog edge after capture, unless an overflow happens on that same edge. Power-on reset also sets the flag to 1.
- R9: With `cfg_enable` at 0, the block never raises `sys_reset_req` or `wake_req`, and `timeout_n` stays at 1.
- R10: While the power-on resets are active, `sys_reset_req` and `wake_req` are 0 and `timeout_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Free-running watchdog clock |
| wd_por_n | input | 1 | Active-low power-on reset, watchdog domain |
| sys_clk | input | 1 | Processor system clock, may be stopped in sleep |
| sys_por_n | input | 1 | Active-low power-on reset, system domain |
| cfg_enable | input | 1 | Static enable strap, 1 = active |
| feed_req | input | 1 | One-cycle feed request, system domain |
| status_clr | input | 1 | One-cycle request to set the timeout flag to 1, system domain |
| cpu_sleep | input | 1 | Level, 1 while the processor sleeps |
| sys_reset_req | output | 1 | Reset request, watchdog domain, held RST_CYCLES cycles |
| wake_req | output | 1 | One-cycle wake request, watchdog domain |
| timeout_n | output | 1 | Active-low timeout flag, synchronized to system domain |

## Verification
The counter is not visible at the ports. A wrong count or a feed that was lost or applied twice shows up only as an overflow that comes early, comes late or is missing. That error appears at `sys_reset_req` or `wake_req` one TIMEOUT period later at most. The bench therefore runs a behavioural model that predicts both outputs on every watchdog cycle, so the fault is reported on the first edge where the outputs diverge. A flag error shows at `timeout_n` two system cycles after the watchdog edge that caused it. A wrongly synchronized sleep level shows as a reset in place of a wake during the stopped-clock phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WDT_ACT_NONE  = 2'd0,
        WDT_ACT_RESET = 2'd1,
        WDT_ACT_WAKE  = 2'd2
    } wdt_act_e;

    function automatic wdt_act_e wdt_pick_action(input logic asleep);
        return asleep ? WDT_ACT_WAKE : WDT_ACT_RESET;
    endfunction

endpackage

// File: rtl/wdt_level_sync.sv
module wdt_level_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_pulse_xfer.sv
module wdt_pulse_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog_d, tog_q;
    logic tog_sync;
    logic seen_d, seen_q;

    always_comb tog_d = tog_q ^ src_pulse;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) tog_q <= 1'b0;
        else            tog_q <= tog_d;
    end

    wdt_level_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tog_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .din   (tog_q),
        .dout  (tog_sync)
    );

    always_comb seen_d = tog_sync;

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) seen_q <= 1'b0;
        else            seen_q <= seen_d;
    end

    assign dst_pulse = tog_sync ^ seen_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int TIMEOUT    = 1024,
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic feed_pulse,
    input  logic clr_pulse,
    input  logic asleep,
    output logic rst_req,
    output logic wake_req,
    output logic timeout_n
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam int LW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam logic [LW-1:0] HOLD_LEN = LW'(RST_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
        logic [LW-1:0] left;
        logic          wake;
        logic          tn;
    } core_st_t;

    core_st_t st_d, st_q;
    wdt_act_e act;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        act       = WDT_ACT_NONE;
        if (enable) begin
            if (st_q.hold) begin
                st_d.cnt  = '0;
                st_d.left = st_q.left - LW'(1);
                st_d.hold = (st_q.left != LW'(1));
            end else if (feed_pulse) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                act      = wdt_pick_action(asleep);
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        if (clr_pulse) st_d.tn = 1'b1;
        case (act)
            WDT_ACT_RESET: begin
                st_d.hold = 1'b1;
                st_d.left = HOLD_LEN;
                st_d.tn   = 1'b0;
            end
            WDT_ACT_WAKE: begin
                st_d.wake = 1'b1;
                st_d.tn   = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.hold <= 1'b0;
            st_q.left <= '0;
            st_q.wake <= 1'b0;
            st_q.tn   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req   = st_q.hold;
    assign wake_req  = st_q.wake;
    assign timeout_n = st_q.tn;

    AST_FEED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && feed_pulse && !st_q.hold) |=> (st_q.cnt == '0)); // R2

    AST_HOLD_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold |-> (st_q.cnt == '0)); // R3

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |=> !st_q.wake); // R4

    AST_WAKE_NOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> !st_q.hold); // R4

    AST_RESET_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hold) |-> !$past(asleep)); // R5

    AST_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.hold) || st_q.wake) |-> !st_q.tn); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!st_q.hold && !st_q.wake)); // R9
endmodule

// File: rtl/wdt_sleep_aware.sv
module wdt_sleep_aware #(
    parameter int TIMEOUT     = 1024,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic wd_clk,
    input  logic wd_por_n,
    input  logic sys_clk,
    input  logic sys_por_n,
    input  logic cfg_enable,
    input  logic feed_req,
    input  logic status_clr,
    input  logic cpu_sleep,
    output logic sys_reset_req,
    output logic wake_req,
    output logic timeout_n
);
    logic feed_pulse;
    logic clr_pulse;
    logic sleep_sync;
    logic flag_wd;

    wdt_pulse_xfer #(.STAGES(SYNC_STAGES)) u_feed_xfer (
        .src_clk   (sys_clk),
        .src_rst_n (sys_por_n),
        .src_pulse (feed_req),
        .dst_clk   (wd_clk),
        .dst_rst_n (wd_por_n),
        .dst_pulse (feed_pulse)
    );

    wdt_pulse_xfer #(.STAGES(SYNC_STAGES)) u_clr_xfer (
        .src_clk   (sys_clk),
        .src_rst_n (sys_por_n),
        .src_pulse (status_clr),
        .dst_clk   (wd_clk),
        .dst_rst_n (wd_por_n),
        .dst_pulse (clr_pulse)
    );

    wdt_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
        .clk   (wd_clk),
        .rst_n (wd_por_n),
        .din   (cpu_sleep),
        .dout  (sleep_sync)
    );

    wdt_core #(.TIMEOUT(TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk        (wd_clk),
        .rst_n      (wd_por_n),
        .enable     (cfg_enable),
        .feed_pulse (feed_pulse),
        .clr_pulse  (clr_pulse),
        .asleep     (sleep_sync),
        .rst_req    (sys_reset_req),
        .wake_req   (wake_req),
        .timeout_n  (flag_wd)
    );

    wdt_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_flag_sync (
        .clk   (sys_clk),
        .rst_n (sys_por_n),
        .din   (flag_wd),
        .dout  (timeout_n)
    );
endmodule

// File: tb/tb_wdt_sleep_aware.sv
module tb_wdt_sleep_aware;
    localparam int TIMEOUT    = 16;
    localparam int RST_CYCLES = 4;

    logic sys_raw = 1'b0;
    logic sys_run = 1'b1;
    logic sys_clk;
    logic wd_clk = 1'b0;
    logic wd_por_n = 1'b0, sys_por_n = 1'b0;
    logic feed_req = 1'b0, status_clr = 1'b0, cpu_sleep = 1'b0;
    logic rst_o, wake_o, tn_o;
    logic rst_x, wake_x, tn_x;

    assign sys_clk = sys_raw & sys_run;
    always #2.5 sys_raw = ~sys_raw;
    initial begin
        #4;
        forever begin wd_clk = 1'b1; #20; wd_clk = 1'b0; #20; end
    end

    wdt_sleep_aware #(.TIMEOUT(TIMEOUT), .RST_CYCLES(RST_CYCLES)) dut (
        .wd_clk(wd_clk), .wd_por_n(wd_por_n), .sys_clk(sys_clk), .sys_por_n(sys_por_n),
        .cfg_enable(1'b1), .feed_req(feed_req), .status_clr(status_clr), .cpu_sleep(cpu_sleep),
        .sys_reset_req(rst_o), .wake_req(wake_o), .timeout_n(tn_o));

    wdt_sleep_aware #(.TIMEOUT(TIMEOUT), .RST_CYCLES(RST_CYCLES)) dut_off (
        .wd_clk(wd_clk), .wd_por_n(wd_por_n), .sys_clk(sys_clk), .sys_por_n(sys_por_n),
        .cfg_enable(1'b0), .feed_req(feed_req), .status_clr(status_clr), .cpu_sleep(cpu_sleep),
        .sys_reset_req(rst_x), .wake_req(wake_x), .timeout_n(tn_x));

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  feed_sent = 0, feed_seen = 0, clr_sent = 0, clr_seen = 0;
    int  m_cnt = 0, m_left = 0, m_wake_total = 0;
    bit  m_rst = 0, m_wake = 0, m_tn = 1;
    bit  fp0 = 0, fp1 = 0, cp0 = 0, cp1 = 0, sl0 = 0, sl1 = 0;
    bit  f_now, c_now, s_now, ovf;
    bit  so1 = 1, so2 = 1;

    always @(posedge wd_clk or negedge wd_por_n) begin
        if (!wd_por_n) begin
            m_cnt = 0; m_left = 0; m_rst = 0; m_wake = 0; m_tn = 1;
            fp0 = 0; fp1 = 0; cp0 = 0; cp1 = 0; sl0 = 0; sl1 = 0;
            feed_seen = feed_sent; clr_seen = clr_sent;
        end else begin
            f_now = fp1; c_now = cp1; s_now = sl1;
            fp1 = fp0; fp0 = (feed_sent != feed_seen); feed_seen = feed_sent;
            cp1 = cp0; cp0 = (clr_sent != clr_seen);   clr_seen = clr_sent;
            sl1 = sl0; sl0 = cpu_sleep;
            m_wake = 0; ovf = 0;
            if (m_rst) begin
                m_cnt = 0; m_left = m_left - 1;
                if (m_left == 0) m_rst = 0;
            end else if (f_now) m_cnt = 0;
            else if (m_cnt == TIMEOUT - 1) begin m_cnt = 0; ovf = 1; end
            else m_cnt = m_cnt + 1;
            if (c_now) m_tn = 1;
            if (ovf) begin
                m_tn = 0;
                if (s_now) begin m_wake = 1; m_wake_total++; end
                else begin m_rst = 1; m_left = RST_CYCLES; end
            end
        end
    end

    always @(posedge sys_clk or negedge sys_por_n) begin
        if (!sys_por_n) begin so1 = 1; so2 = 1; end
        else begin so2 = so1; so1 = m_tn; end
    end

    int wake_seen = 0, rst_rises = 0, off_events = 0;
    bit rst_prev = 0;

    always @(negedge wd_clk) begin
        if (wd_por_n) begin
            chk(rst_o == m_rst, "R3 sys_reset_req vs model", rst_o, m_rst);
            chk(wake_o == m_wake, "R4 wake_req vs model", wake_o, m_wake);
            chk(!rst_x && !wake_x, "R9 disabled outputs", {rst_x, wake_x}, 0);
            if (wake_o) wake_seen++;
            if (rst_o && !rst_prev) rst_rises++;
            if (rst_x || wake_x) off_events++;
            rst_prev = rst_o;
        end else rst_prev = 0;
    end

    always @(negedge sys_clk) begin
        if (sys_por_n) begin
            chk(tn_o == so2, "R7 timeout_n vs model", tn_o, so2);
            chk(tn_x == 1'b1, "R9 disabled timeout_n", tn_x, 1);
        end
    end

    task automatic do_feed();
        @(negedge sys_clk); feed_req = 1'b1; feed_sent++;
        @(negedge sys_clk); feed_req = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge sys_clk); status_clr = 1'b1; clr_sent++;
        @(negedge sys_clk); status_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge sys_raw);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, w, rises0, wakes0, mw0;
        #10;
        chk(rst_o == 0 && wake_o == 0, "R10 outputs in reset", {rst_o, wake_o}, 0);
        chk(tn_o == 1, "R10 timeout_n in reset", tn_o, 1);
        @(negedge wd_clk); #3; wd_por_n = 1'b1; sys_por_n = 1'b1;

        // R1: first overflow after TIMEOUT edges, awake -> reset
        n = 0;
        do begin @(posedge wd_clk); n++; @(negedge wd_clk); end while (!rst_o);
        chk(n == TIMEOUT, "R1 edges to first overflow", n, TIMEOUT);
        // R3: feed during hold ignored, hold width
        w = 1;
        do_feed();
        forever begin @(negedge wd_clk); if (rst_o) w++; else break; end
        chk(w == RST_CYCLES, "R3 reset hold width", w, RST_CYCLES);
        chk(tn_o == 0, "R7 flag stays low after reset hold", tn_o, 0);
        n = 0;
        do begin @(posedge wd_clk); n++; @(negedge wd_clk); end while (!rst_o);
        chk(n == TIMEOUT, "R3 restart from zero after hold", n, TIMEOUT);
        while (rst_o) @(negedge wd_clk);

        // R8: software clear
        do_clr();
        repeat (4) @(negedge wd_clk);
        chk(tn_o == 1, "R8 clear sets flag", tn_o, 1);

        // R2: regular feeds prevent overflow
        rises0 = rst_rises;
        for (int i = 0; i < 10; i++) begin
            do_feed();
            repeat (8) @(posedge wd_clk);
        end
        chk(rst_rises == rises0, "R2 no reset while fed", rst_rises, rises0);
        chk(tn_o == 1, "R2 flag untouched while fed", tn_o, 1);

        // R4/R5/R6: sleep with system clock stopped
        @(negedge sys_clk); cpu_sleep = 1'b1;
        @(negedge sys_raw); sys_run = 1'b0;
        wakes0 = wake_seen; mw0 = m_wake_total;
        repeat (3 * TIMEOUT) @(negedge wd_clk);
        chk(wake_seen - wakes0 == m_wake_total - mw0, "R6 wakes with clock stopped",
            wake_seen - wakes0, m_wake_total - mw0);
        chk(wake_seen - wakes0 >= 2, "R4 wake requests issued", wake_seen - wakes0, 2);
        chk(rst_rises == rises0, "R5 no reset while asleep", rst_rises, rises0);
        @(negedge sys_raw); sys_run = 1'b1;
        cpu_sleep = 1'b0;
        repeat (4) @(negedge sys_clk);
        chk(tn_o == 0, "R7 flag low after wake overflow", tn_o, 0);

        // R10/R8: power-on reset restores flag
        @(negedge wd_clk); #3; wd_por_n = 1'b0; sys_por_n = 1'b0;
        #20;
        chk(rst_o == 0 && wake_o == 0, "R10 outputs during por", {rst_o, wake_o}, 0);
        chk(tn_o == 1, "R8 por sets flag", tn_o, 1);
        @(negedge wd_clk); #3; wd_por_n = 1'b1; sys_por_n = 1'b1;
        repeat (TIMEOUT + 2 * RST_CYCLES) @(negedge wd_clk);
        chk(off_events == 0, "R9 disabled never acted", off_events, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule